// File: doc/BRIEF.md
# Multi-channel APB down-counter timer

This block is an APB slave that holds several independent down-counting timer channels; the default build has two. Each channel counts down one step per clock from a programmed value. When it steps past zero it reloads, either from its load register (periodic mode) or with all ones (free-running mode), and raises a sticky interrupt flag. Software enables a channel by setting its enable bit, which copies the load value into the counter. It reads the current count; inverting that value gives an up-count. It acknowledges an interrupt by reading a per-channel acknowledge register, or by reading one shared register that acknowledges every channel at once.

A mask bit in each channel's control register blocks that channel's interrupt output but leaves the raw flag visible. Shared registers report the masked and raw flags of all channels as bit vectors and give a fixed version word. The interface has zero wait states and never signals an error.

Top module: `apb_dn_timer`

## Requirements
- R1: PREADY is always 1 and PSLVERR is always 0. Every transfer completes in its first access cycle, and reads of unmapped addresses (including 0x28, 0x30 and 0xB0 in the two-channel build) return 0.
- R2: Channel n decodes the window starting at 0x14*n. The registers in that window are: load at +0x00 (read/write), current count at +0x04, control at +0x08, acknowledge at +0x0C and masked status at +0x10 (bit 0). Only control bits [2:0] are stored, and the other control bits read 0.
- R3: A control write that changes bit 0 (enable) from 0 to 1 copies the load value into the counter. While enabled, the counter then drops by one on every clock, so a load value L expires on the (L+1)-th clock after the enabling write.
- R4: With control bit 1 = 1 (periodic), expiry at count 0 reloads the counter from the load register.
- R5: With control bit 1 = 0 (free-running), expiry at count 0 reloads the counter with 0xFFFFFFFF.
- R6: Expiry sets the channel's raw flag whatever the mask. The per-channel interrupt output is the raw flag gated by control bit 2 (mask, 1 = blocked), and the combined output is the OR of the per-channel outputs.
- R7: A read of a channel's acknowledge register clears that channel's raw flag, and a write to it has no effect. If an expiry falls on the same clock as the clear, the flag stays set.
- R8: Shared register 0xA0 returns the masked flags and 0xA8 the raw flags, channel n in bit n. A read of 0xA4 clears the raw flags of all channels.
- R9: While the enable bit is 0 the counter holds its value and no new raw flag is raised.
- R10: Register 0xAC returns the VERSION parameter.
- R11: Writes to the current count register are ignored: they change neither the count nor the load register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and counting clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 8 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid in the access cycle |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| tmr_irq | output | NUM_CH | Per-channel masked interrupt |
| irq_any | output | 1 | OR of all channel interrupts |

## Verification
A register write commits on the clock edge that ends its access cycle, and read data is combinational, so the bench samples PRDATA one time step into the access cycle. A count read therefore shows the value after one edge of counting past the preceding transfer. After an enabling write with load L, the interrupt output is still low L clock cycles later and is high one cycle after that. The directed tasks step through exactly those edge counts and sample at falling edges. A clear by read takes effect on the read's access edge and is checked at the falling edge that follows it. Masking takes effect on the edge of the control write.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 8;
  localparam int CH_STRIDE = 20;

  // per-channel register offsets inside a window
  localparam logic [ADDR_W-1:0] OFF_LOAD = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_CUR  = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_CTL  = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_ACK  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_STAT = 8'h10;

  // shared registers
  localparam logic [ADDR_W-1:0] SH_MIS = 8'hA0;
  localparam logic [ADDR_W-1:0] SH_CLR = 8'hA4;
  localparam logic [ADDR_W-1:0] SH_RAW = 8'hA8;
  localparam logic [ADDR_W-1:0] SH_VER = 8'hAC;

  // control field: bit 2 mask, bit 1 periodic, bit 0 enable
  typedef struct packed {
    logic mask;
    logic periodic;
    logic enable;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);
endpackage

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_we,
  input  logic              ctl_we,
  input  logic              clr_req,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  load_o,
  output logic [CNT_W-1:0]  cnt_o,
  output ctl_t              ctl_o,
  output logic              raw_o
);
  logic [CNT_W-1:0] load_q, load_nx;
  logic [CNT_W-1:0] cnt_q, cnt_nx, reload_val;
  ctl_t             ctl_q, ctl_nx;
  logic             raw_q, raw_nx;
  logic             start, run, expire, cnt_en, raw_en;

  // next-state
  always_comb begin
    load_nx    = wdata[CNT_W-1:0];
    ctl_nx     = ctl_t'(wdata[CTL_W-1:0]);
    start      = ctl_we & ctl_nx.enable & ~ctl_q.enable;
    run        = ctl_q.enable & (~ctl_we | ctl_nx.enable);
    expire     = run & (cnt_q == '0);
    reload_val = ctl_q.periodic ? load_q : '1;
    if (start)       cnt_nx = load_q;
    else if (expire) cnt_nx = reload_val;
    else             cnt_nx = cnt_q - CNT_W'(1);
    cnt_en = start | run;
    // expiry has priority over a clear in the same cycle
    raw_nx = expire;
    raw_en = expire | clr_req;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
      ctl_q  <= '0;
      cnt_q  <= '0;
      raw_q  <= 1'b0;
    end else begin
      if (ld_we)  load_q <= load_nx;
      if (ctl_we) ctl_q  <= ctl_nx;
      if (cnt_en) cnt_q  <= cnt_nx;
      if (raw_en) raw_q  <= raw_nx;
    end
  end

  assign load_o = load_q;
  assign cnt_o  = cnt_q;
  assign ctl_o  = ctl_q;
  assign raw_o  = raw_q;
endmodule

// File: rtl/tmr_apb_dec.sv
module tmr_apb_dec
  import tmr_pkg::*;
#(
  parameter int          NUM_CH  = 2,
  parameter int          CNT_W   = 32,
  parameter logic [31:0] VERSION = 32'h5444_0107
) (
  input  logic                         psel,
  input  logic                         penable,
  input  logic                         pwrite,
  input  logic [ADDR_W-1:0]            paddr,
  input  logic [NUM_CH-1:0][CNT_W-1:0] ch_load,
  input  logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt,
  input  ctl_t [NUM_CH-1:0]            ch_ctl,
  input  logic [NUM_CH-1:0]            ch_raw,
  input  logic [NUM_CH-1:0]            ch_mis,
  output logic [NUM_CH-1:0]            ld_we,
  output logic [NUM_CH-1:0]            ctl_we,
  output logic [NUM_CH-1:0]            ack_rd,
  output logic                         clr_all,
  output logic [DATA_W-1:0]            prdata
);
  logic              wr_acc, rd_acc;
  logic [DATA_W-1:0] ch_word [NUM_CH];
  logic [DATA_W-1:0] sh_word;

  assign wr_acc  = psel & penable & pwrite;
  assign rd_acc  = psel & penable & ~pwrite;
  assign clr_all = rd_acc & (paddr == SH_CLR);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(i * CH_STRIDE);
    localparam logic [ADDR_W:0] HI = (ADDR_W+1)'((i + 1) * CH_STRIDE);
    logic              hit;
    logic [ADDR_W-1:0] off;
    logic [DATA_W-1:0] word;

    assign hit = ({1'b0, paddr} >= LO) && ({1'b0, paddr} < HI);
    assign off = paddr - LO[ADDR_W-1:0];

    assign ld_we[i]  = wr_acc & hit & (off == OFF_LOAD);
    assign ctl_we[i] = wr_acc & hit & (off == OFF_CTL);
    assign ack_rd[i] = rd_acc & hit & (off == OFF_ACK);

    always_comb begin
      word = '0;
      if (hit) begin
        case (off)
          OFF_LOAD: word[CNT_W-1:0] = ch_load[i];
          OFF_CUR:  word[CNT_W-1:0] = ch_cnt[i];
          OFF_CTL:  word[CTL_W-1:0] = ch_ctl[i];
          OFF_STAT: word[0]         = ch_mis[i];
          default:  word = '0;
        endcase
      end
    end
    assign ch_word[i] = word;
  end

  always_comb begin
    sh_word = '0;
    case (paddr)
      SH_MIS:  sh_word[NUM_CH-1:0] = ch_mis;
      SH_RAW:  sh_word[NUM_CH-1:0] = ch_raw;
      SH_VER:  sh_word = VERSION;
      default: sh_word = '0;
    endcase
    prdata = sh_word;
    for (int i = 0; i < NUM_CH; i++) prdata = prdata | ch_word[i];
  end
endmodule

// File: rtl/apb_dn_timer.sv
module apb_dn_timer
  import tmr_pkg::*;
#(
  parameter int          NUM_CH  = 2,
  parameter int          CNT_W   = 32,
  parameter logic [31:0] VERSION = 32'h5444_0107
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  output logic [NUM_CH-1:0] tmr_irq,
  output logic              irq_any
);
  logic                         rst_meta, rst_n_s;
  logic [NUM_CH-1:0][CNT_W-1:0] ch_load, ch_cnt;
  ctl_t [NUM_CH-1:0]            ch_ctl;
  logic [NUM_CH-1:0]            ch_raw, ch_mis;
  logic [NUM_CH-1:0]            ld_we, ctl_we, ack_rd;
  logic                         clr_all;

  // asynchronous assert, synchronous release
  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  tmr_apb_dec #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .VERSION(VERSION)
  ) u_dec (
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .ch_load(ch_load), .ch_cnt(ch_cnt), .ch_ctl(ch_ctl),
    .ch_raw(ch_raw), .ch_mis(ch_mis),
    .ld_we(ld_we), .ctl_we(ctl_we), .ack_rd(ack_rd),
    .clr_all(clr_all), .prdata(prdata)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    tmr_chan #(.CNT_W(CNT_W)) u_chan (
      .clk(pclk), .rst_n(rst_n_s),
      .ld_we(ld_we[i]), .ctl_we(ctl_we[i]),
      .clr_req(ack_rd[i] | clr_all),
      .wdata(pwdata),
      .load_o(ch_load[i]), .cnt_o(ch_cnt[i]),
      .ctl_o(ch_ctl[i]), .raw_o(ch_raw[i])
    );
    assign ch_mis[i] = ch_raw[i] & ~ch_ctl[i].mask;
  end

  assign tmr_irq = ch_mis;
  assign irq_any = |ch_mis;
  assign pready  = 1'b1;
  assign pslverr = 1'b0;
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 32
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         pready,
  input logic                         pslverr,
  input ctl_t [NUM_CH-1:0]            ctl,
  input logic [NUM_CH-1:0][CNT_W-1:0] cnt,
  input logic [NUM_CH-1:0][CNT_W-1:0] load,
  input logic [NUM_CH-1:0]            raw,
  input logic [NUM_CH-1:0]            irq
);
  AST_APB_OKAY: assert property (@(posedge clk) disable iff (!rst_n)
    pready && !pslverr); // R1

  for (genvar i = 0; i < NUM_CH; i++) begin : g_c
    AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl[i].enable && !$past(ctl[i].enable)) |-> (cnt[i] == $past(load[i]))); // R3

    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl[i].enable && $past(ctl[i].enable) && $past(cnt[i]) != '0)
        |-> (cnt[i] == $past(cnt[i]) - CNT_W'(1))); // R3

    AST_PERIOD_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl[i].enable && $past(ctl[i].enable) && $past(cnt[i]) == '0 && $past(ctl[i].periodic))
        |-> (cnt[i] == $past(load[i]))); // R4

    AST_FREE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl[i].enable && $past(ctl[i].enable) && $past(cnt[i]) == '0 && !$past(ctl[i].periodic))
        |-> (cnt[i] == '1)); // R5

    AST_RAW_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl[i].enable && $past(ctl[i].enable) && $past(cnt[i]) == '0) |-> raw[i]); // R6

    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      ctl[i].mask |-> !irq[i]); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl[i].enable && !$past(ctl[i].enable)) |-> $stable(cnt[i])); // R9

    AST_IDLE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl[i].enable && !$past(ctl[i].enable)) |-> !$rose(raw[i])); // R9
  end
endmodule

bind apb_dn_timer tmr_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk(pclk), .rst_n(rst_n_s), .pready(pready), .pslverr(pslverr),
  .ctl(ch_ctl), .cnt(ch_cnt), .load(ch_load), .raw(ch_raw), .irq(tmr_irq)
);

// File: tb/sim_apb_dn_timer.sv
`timescale 1ns/1ps
module sim_apb_dn_timer;
  localparam logic [31:0] VER = 32'h5444_0107;

  logic        pclk = 1'b0;
  logic        presetn;
  logic        psel, penable, pwrite;
  logic [7:0]  paddr;
  logic [31:0] pwdata, prdata;
  logic        pready, pslverr;
  logic [1:0]  tmr_irq;
  logic        irq_any;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 pclk = ~pclk;

  apb_dn_timer #(.NUM_CH(2), .CNT_W(32), .VERSION(VER)) u0 (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .tmr_irq(tmr_irq), .irq_any(irq_any)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge pclk);
  endtask

  // starts and ends on a falling edge; commits on the edge in between
  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge pclk); penable = 1'b1;
    @(negedge pclk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge pclk); penable = 1'b1;
    #1 d = prdata;
    @(negedge pclk); psel = 1'b0; penable = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 pready", {31'b0, pready}, 32'd1);
    chk("R1 pslverr", {31'b0, pslverr}, 32'd0);
    chk("R6 irq after reset", {29'b0, irq_any, tmr_irq}, 32'd0);
    apb_rd(8'h1C, d); chk("R2 ch1 ctrl reset", d, 32'd0);
    apb_rd(8'hA8, d); chk("R8 raw reset", d, 32'd0);
    apb_rd(8'h04, d); chk("R2 ch0 count reset", d, 32'd0);
  endtask

  task automatic t_map;
    logic [31:0] d;
    apb_rd(8'hAC, d); chk("R10 version", d, VER);
    apb_wr(8'h30, 32'hDEAD_BEEF);
    apb_rd(8'h28, d); chk("R1 unmapped 0x28", d, 32'd0);
    apb_rd(8'h30, d); chk("R1 unmapped 0x30", d, 32'd0);
    apb_rd(8'hB0, d); chk("R1 unmapped 0xB0", d, 32'd0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    apb_wr(8'h00, 32'h1234_5678);
    apb_rd(8'h00, d); chk("R2 load readback", d, 32'h1234_5678);
    apb_wr(8'h08, 32'hFFFF_FFF8);
    apb_rd(8'h08, d); chk("R2 ctrl upper bits", d, 32'd0);
    apb_wr(8'h04, 32'hAAAA_5555);
    apb_rd(8'h04, d); chk("R11 count write ignored", d, 32'd0);
    apb_rd(8'h00, d); chk("R11 load untouched", d, 32'h1234_5678);
  endtask

  task automatic t_periodic;
    logic [31:0] d;
    apb_wr(8'h00, 32'd5);
    apb_wr(8'h08, 32'd3);          // periodic, enabled, unmasked
    wait_cyc(5);
    chk("R3 no irq before expiry", {30'b0, tmr_irq}, 32'd0);
    wait_cyc(1);
    chk("R3 irq at L+1", {30'b0, tmr_irq}, 32'd1);
    chk("R6 combined irq", {31'b0, irq_any}, 32'd1);
    apb_rd(8'h10, d); chk("R2 ch0 status", d, 32'd1);
    apb_rd(8'h0C, d);
    chk("R7 ack read clears", {30'b0, tmr_irq}, 32'd0);
    wait_cyc(1);
    chk("R4 still counting", {30'b0, tmr_irq}, 32'd0);
    wait_cyc(1);
    chk("R4 periodic re-expiry", {30'b0, tmr_irq}, 32'd1);
    apb_rd(8'h04, d); chk("R4 reload from load", d, 32'd4);
    apb_wr(8'h08, 32'd2);          // disable
    apb_rd(8'h0C, d);
    apb_rd(8'h04, d);
    begin
      logic [31:0] d2;
      wait_cyc(20);
      apb_rd(8'h04, d2); chk("R9 count holds", d2, d);
    end
    apb_rd(8'hA8, d); chk("R9 no flag while idle", d, 32'd0);
  endtask

  task automatic t_freerun;
    logic [31:0] d;
    apb_wr(8'h14, 32'd3);
    apb_wr(8'h1C, 32'd1);          // free-running, enabled
    apb_rd(8'h18, d); chk("R3 count step", d, 32'd2);
    wait_cyc(2);
    chk("R6 ch1 irq", {30'b0, tmr_irq}, 32'd2);
    apb_rd(8'h18, d); chk("R5 all-ones reload", d, 32'hFFFF_FFFE);
  endtask

  task automatic t_mask_ack;
    logic [31:0] d;
    apb_wr(8'h1C, 32'd5);          // mask on, stays enabled
    chk("R6 mask blocks", {29'b0, irq_any, tmr_irq}, 32'd0);
    apb_rd(8'hA8, d); chk("R8 raw shows masked", d, 32'd2);
    apb_rd(8'hA0, d); chk("R8 masked vector", d, 32'd0);
    apb_rd(8'h24, d); chk("R2 ch1 status masked", d, 32'd0);
    apb_wr(8'h20, 32'hFFFF_FFFF);
    apb_rd(8'hA8, d); chk("R7 ack write no effect", d, 32'd2);
    apb_rd(8'h20, d);
    apb_rd(8'hA8, d); chk("R7 ch1 ack read clears", d, 32'd0);
  endtask

  task automatic t_clear_all;
    logic [31:0] d;
    apb_wr(8'h00, 32'd2);
    apb_wr(8'h08, 32'd1);
    apb_wr(8'h1C, 32'd0);
    apb_wr(8'h14, 32'd2);
    apb_wr(8'h1C, 32'd1);
    wait_cyc(10);
    apb_rd(8'hA8, d); chk("R8 both raw", d, 32'd3);
    apb_rd(8'hA0, d); chk("R8 both masked-status", d, 32'd3);
    chk("R6 combined high", {31'b0, irq_any}, 32'd1);
    apb_rd(8'hA4, d);
    apb_rd(8'hA8, d); chk("R8 clear-all", d, 32'd0);
    chk("R8 combined low", {31'b0, irq_any}, 32'd0);
  endtask

  initial begin
    presetn = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    paddr = '0; pwdata = '0;
    wait_cyc(3);
    presetn = 1'b1;
    wait_cyc(4);
    t_reset();
    t_map();
    t_regs();
    t_periodic();
    t_freerun();
    t_mask_ack();
    t_clear_all();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge pclk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule